// File: doc/BRIEF.md
# Host Memory Command to TileLink Bridge

This block sits between a simple host command port and a serialized TileLink uncached-lightweight link. The host presents an address, a 32-bit word, a byte enable and a read/write flag with a valid/ready handshake. The bridge turns each command into a single-beat A-channel message, packed as one flat 123-bit word, and sends it over a valid/ready pair. It then waits for the matching D-channel beat and returns either the read word or a write acknowledgement on a response handshake.

The target system is 32 bits wide but the link carries a 64-bit data lane. The bridge therefore places the word in the half of the lane chosen by address bit 2, keeps the other half at zero, and builds a byte mask that covers only the bytes used. Only one command is in flight at a time. There is no timeout: if no response arrives, the bridge stays busy indefinitely.

Top module: `tl_cmd_bridge`

## Requirements
- R1: After reset, `a_valid`, `d_ready`, `rsp_valid` and `busy` are 0 and `cmd_ready` is 1.
- R2: A-channel packet fields, from bit 122 down to bit 0: channel id [122:120] = 0, opcode [119:117], param [116:114] = 0, size [113:110] = 2, source [109:106] = 0, address [105:74] = the command address, data [73:10], corrupt [9] = 0, mask [8:1], last [0] = 1.
- R3: A read emits opcode 4 with all data bits 0. Its mask is 0x0F when address bit 2 is 0 and 0xF0 when address bit 2 is 1.
- R4: A write with byte enable 0xF emits opcode 0. Any other byte enable emits opcode 1. The word sits in data[31:0] when address bit 2 is 0 and in data[63:32] when it is 1. The other half is 0. The mask is the byte enable placed in the same half.
- R5: While `a_valid` is high and `a_ready` is low, `a_valid` stays high and `a_bits` does not change.
- R6: A D beat with channel id 3 [122:120] and opcode 1 [119:117] completes a pending read. `rsp_rdata` is taken from d_bits data[31:0] (bits 41:10) when address bit 2 was 0, or from data[63:32] (bits 73:42) when it was 1. `rsp_write` is 0.
- R7: A D beat with channel id 3 and opcode 0 completes a pending write with `rsp_write` = 1.
- R8: A D beat whose channel id is not 3, or whose opcode does not fit the pending command, is consumed and has no effect: no response is produced and `busy` stays 1.
- R9: `busy` is 1 and `cmd_ready` is 0 from the cycle after a command is accepted until the response is taken. With no D beat, this lasts indefinitely.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_rdata` and `rsp_write` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Bridge can accept a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 32 | Byte address |
| cmd_wdata | input | 32 | Write word |
| cmd_be | input | 4 | Write byte enables |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_write | output | 1 | 1 = write acknowledge, 0 = read data |
| rsp_rdata | output | 32 | Read word |
| a_valid | output | 1 | A-channel packet valid |
| a_ready | input | 1 | Link accepts the A packet |
| a_bits | output | 123 | A-channel packet |
| d_valid | input | 1 | D-channel packet valid |
| d_ready | output | 1 | Bridge accepts a D packet |
| d_bits | input | 123 | D-channel packet |
| busy | output | 1 | A command is in flight |

## Verification
Each result comes from one register stage. A command accepted at a rising edge shows `a_valid` and the packet after that same edge. A D beat taken at an edge raises `rsp_valid` after that edge. A response taken at an edge returns the bridge to idle after that edge. The bench drives and samples on the falling edge, so every check reads the state one rising edge after its stimulus. Holds are checked by stalling `a_ready` or `rsp_ready` for extra cycles and sampling again at each falling edge.

// File: rtl/tl_cmd_bridge.sv
module tl_cmd_bridge #(
  parameter int PKT_W = 123
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [31:0]      cmd_addr,
  input  logic [31:0]      cmd_wdata,
  input  logic [3:0]       cmd_be,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_write,
  output logic [31:0]      rsp_rdata,
  output logic             a_valid,
  input  logic             a_ready,
  output logic [PKT_W-1:0] a_bits,
  input  logic             d_valid,
  output logic             d_ready,
  input  logic [PKT_W-1:0] d_bits,
  output logic             busy
);
  localparam logic [2:0] CH_A = 3'd0, CH_D = 3'd3;
  localparam logic [2:0] OP_GET = 3'd4, OP_PUTF = 3'd0, OP_PUTP = 3'd1;
  localparam logic [2:0] OP_ACK = 3'd0, OP_ACKD = 3'd1;

  typedef enum logic [1:0] {IDLE, SEND, WAIT, RESP} st_t;
  st_t st;
  logic pend_wr, pend_hi;

  wire       take_cmd = cmd_valid && cmd_ready;
  wire [3:0] be_eff   = cmd_write ? cmd_be : 4'hF;
  wire [2:0] op_sel   = !cmd_write ? OP_GET : (cmd_be == 4'hF ? OP_PUTF : OP_PUTP);
  wire [31:0] wword   = cmd_write ? cmd_wdata : 32'h0;
  wire [63:0] lane    = cmd_addr[2] ? {wword, 32'h0} : {32'h0, wword};
  wire [7:0]  mask    = cmd_addr[2] ? {be_eff, 4'h0} : {4'h0, be_eff};

  wire [2:0]  d_ch    = d_bits[122:120];
  wire [2:0]  d_op    = d_bits[119:117];
  wire [63:0] d_data  = d_bits[73:10];
  wire        d_hit   = d_valid && d_ready && d_ch == CH_D &&
                        d_op == (pend_wr ? OP_ACK : OP_ACKD);

  assign cmd_ready = (st == IDLE);
  assign a_valid   = (st == SEND);
  assign d_ready   = (st == WAIT);
  assign rsp_valid = (st == RESP);
  assign busy      = (st != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      pend_wr   <= 1'b0;
      pend_hi   <= 1'b0;
      a_bits    <= '0;
      rsp_write <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      case (st)
        IDLE: if (take_cmd) begin
          st      <= SEND;
          pend_wr <= cmd_write;
          pend_hi <= cmd_addr[2];
          a_bits  <= {CH_A, op_sel, 3'd0, 4'd2, 4'd0, cmd_addr, lane, 1'b0, mask, 1'b1};
        end
        SEND: if (a_ready) st <= WAIT;
        WAIT: if (d_hit) begin
          st        <= RESP;
          rsp_write <= pend_wr;
          rsp_rdata <= pend_wr ? 32'h0 : (pend_hi ? d_data[63:32] : d_data[31:0]);
        end
        RESP: if (rsp_ready) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  AST_LAST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |-> a_bits[0] && a_bits[122:120] == 3'd0 && !a_bits[9]); // R2

  AST_GET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && a_bits[119:117] == 3'd4 |-> $countones(a_bits[8:1]) == 4 && a_bits[73:10] == '0); // R3

  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && !a_ready |=> a_valid && $stable(a_bits)); // R5

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_valid && rsp_valid) && !(a_valid && d_ready)); // R9

  AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready); // R9

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_write)); // R10

  AST_D_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
    d_ready && d_valid && d_bits[122:120] != 3'd3 |=> !rsp_valid && busy); // R8
endmodule

// File: tb/tl_cmd_bridge_tb.sv
module tl_cmd_bridge_tb_top;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_write = 0, rsp_ready = 0, a_ready = 0, d_valid = 0;
  logic [31:0] cmd_addr = 0, cmd_wdata = 0;
  logic [3:0] cmd_be = 0;
  logic [122:0] d_bits = 0;
  logic cmd_ready, rsp_valid, rsp_write, a_valid, d_ready, busy;
  logic [31:0] rsp_rdata;
  logic [122:0] a_bits;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  tl_cmd_bridge dut_i (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [122:0] exp_pkt(input logic wr, input logic [31:0] ad,
                                           input logic [31:0] wd, input logic [3:0] be);
    logic [2:0] op; logic [63:0] dt; logic [7:0] mk; logic [3:0] b;
    b  = wr ? be : 4'hF;
    op = wr ? ((be == 4'hF) ? 3'd0 : 3'd1) : 3'd4;
    dt = '0; mk = '0;
    if (ad[2]) begin dt[63:32] = wr ? wd : 32'h0; mk[7:4] = b; end
    else       begin dt[31:0]  = wr ? wd : 32'h0; mk[3:0] = b; end
    return {3'd0, op, 3'd0, 4'd2, 4'd0, ad, dt, 1'b0, mk, 1'b1};
  endfunction

  function automatic logic [122:0] d_pkt(input logic [2:0] ch, input logic [2:0] op, input logic [63:0] dt);
    return {ch, op, 3'd0, 4'd2, 4'd0, 32'h0, dt, 1'b0, 8'h0, 1'b1};
  endfunction

  task automatic send_d(input logic [122:0] p);
    d_bits = p; d_valid = 1;
    @(posedge clk); @(negedge clk);
    d_valid = 0;
  endtask

  task automatic issue(input string rq, input logic wr, input logic [31:0] ad,
                       input logic [31:0] wd, input logic [3:0] be, input int stall);
    chk("R9 ready before command", cmd_ready, 1);
    cmd_valid = 1; cmd_write = wr; cmd_addr = ad; cmd_wdata = wd; cmd_be = be;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
    chk("R9 busy after accept", {busy, cmd_ready}, 2'b10);
    chk(rq, a_bits, exp_pkt(wr, ad, wd, be));
    for (int i = 0; i < stall; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R5 A held during stall", {a_valid, a_bits}, {1'b1, exp_pkt(wr, ad, wd, be)});
    end
    a_ready = 1;
    @(posedge clk); @(negedge clk);
    a_ready = 0;
    chk("R9 waiting for D", {a_valid, d_ready, busy}, 3'b011);
  endtask

  task automatic finish_rsp(input string rq, input logic wr, input logic [31:0] rd, input int stall);
    chk(rq, {rsp_valid, rsp_write, rsp_rdata}, {1'b1, wr, rd});
    for (int i = 0; i < stall; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R10 response held", {rsp_valid, rsp_write, rsp_rdata}, {1'b1, wr, rd});
    end
    rsp_ready = 1;
    @(posedge clk); @(negedge clk);
    rsp_ready = 0;
    chk("R9 idle after response", {busy, cmd_ready, rsp_valid}, 3'b010);
  endtask

  task automatic t_read_low();
    issue("R2 R3 read low packet", 0, 32'h0001_0000, 32'h0, 4'h0, 2);
    send_d(d_pkt(3'd3, 3'd1, 64'hDEAD_BEEF_0200_05B7));
    finish_rsp("R6 read low half", 0, 32'h0200_05B7, 1);
  endtask

  task automatic t_read_high();
    issue("R2 R3 read high packet", 0, 32'h0001_0004, 32'h0, 4'h0, 0);
    send_d(d_pkt(3'd2, 3'd1, 64'h1111_1111_2222_2222));
    chk("R8 foreign channel ignored", {rsp_valid, busy, d_ready}, 3'b011);
    send_d(d_pkt(3'd3, 3'd0, 64'h3333_3333_4444_4444));
    chk("R8 wrong opcode ignored", {rsp_valid, busy}, 2'b01);
    repeat (20) @(negedge clk);
    chk("R9 no timeout, still waiting", {busy, d_ready, rsp_valid}, 3'b110);
    send_d(d_pkt(3'd3, 3'd1, 64'hF140_2573_0000_0000));
    finish_rsp("R6 read high half", 0, 32'hF140_2573, 0);
  endtask

  task automatic t_write_full();
    issue("R4 full write low", 1, 32'h8000_0000, 32'hCAFE_F00D, 4'hF, 1);
    send_d(d_pkt(3'd3, 3'd1, 64'h0));
    chk("R8 read-ack for write ignored", {rsp_valid, busy}, 2'b01);
    send_d(d_pkt(3'd3, 3'd0, 64'h0));
    finish_rsp("R7 write ack", 1, 32'h0, 2);
  endtask

  task automatic t_write_partial();
    issue("R4 partial write high", 1, 32'h8000_000C, 32'h0000_AB00, 4'h2, 0);
    send_d(d_pkt(3'd3, 3'd0, 64'h0));
    finish_rsp("R7 partial write ack", 1, 32'h0, 0);
    issue("R4 partial write low", 1, 32'h0200_0000, 32'h0000_0001, 4'h1, 0);
    send_d(d_pkt(3'd3, 3'd0, 64'h0));
    finish_rsp("R7 write ack low", 1, 32'h0, 0);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", {a_valid, d_ready, rsp_valid, busy, cmd_ready}, 5'b00001);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", {a_valid, d_ready, rsp_valid, busy, cmd_ready}, 5'b00001);
    t_read_low();
    t_read_high();
    t_write_full();
    t_write_partial();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule